// File: doc/BRIEF.md
# Page-Splitting DMA Engine

This block is a single-channel direct memory access engine. Software loads a physical start address and a byte count into the engine, then writes a control word. The control word selects the direction and carries a start bit. The engine then moves words between a device stream port and memory on its own, acting as a bus master. When the whole block has moved, it raises an interrupt. Addresses are physical and pass straight to the memory port with no translation.

Memory is treated as pages of `PAGE_BYTES` bytes. The engine never lets a single bus tenure cross a page boundary. Each segment covers either the bytes left in the transfer or the bytes left up to the next boundary, whichever is smaller. Before each segment the engine requests the memory bus and waits for the grant. After the segment it drops the request for at least one cycle, and only then starts the next segment.

Top module: `dma_page_engine`

## Requirements
- R1: Register offsets on `reg_addr`: 0 = start address, 1 = byte length, 2 = control (bit 0 direction: 0 moves device data into memory, 1 moves memory data out to the device; bit 1 = start), 3 = status (bit 0 busy, bit 1 done). Address and length read back as written. Control reads back the direction in bit 0. The two low bits of address and length are ignored by the transfer, which is word aligned (4-byte words).
- R2: After a start with a non-zero length, status busy reads 1. The engine raises `mem_req` and issues no memory command until `mem_gnt` is high. While idle, the memory request, the device ready and the device valid stay low.
- R3: In direction 0, words taken from the device port through `dev_rx_valid`/`dev_rx_ready` are written in arrival order to consecutive word addresses from the start address (`mem_we` = 1).
- R4: In direction 1, memory words read at consecutive addresses (`mem_we` = 0, data taken with `mem_ack`) are presented on the device port in address order through `dev_tx_valid`/`dev_tx_ready`.
- R5: Every accepted memory command within one request tenure falls in the same page. A command is held with its address stable until `mem_ack`. A transfer that starts exactly on a boundary and fills one page uses one tenure.
- R6: `mem_req` drops for at least one cycle between segments, so the number of tenures equals the number of pages the transfer touches.
- R7: On completion, done and `irq` rise and busy reads 0.
- R8: A status read clears done and `irq`. Until that read, `irq` stays high.
- R9: A start with a length below 4 bytes sets done and `irq` without any memory request or device transfer.
- R10: A start written while busy is ignored. No second transfer follows, and the running transfer completes unchanged.
- R11: After reset, status reads 0, `irq` is low and `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears done on status) |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for the indexed register |
| mem_req | output | 1 | Memory bus request, held for one segment |
| mem_gnt | input | 1 | Memory bus grant |
| mem_cmd | output | 1 | Memory command valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Physical word address of the command |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Command accepted; read data valid |
| mem_rdata | input | DW | Read data |
| dev_rx_valid | input | 1 | Device offers a word |
| dev_rx_data | input | DW | Device word toward memory |
| dev_rx_ready | output | 1 | Engine takes the offered word |
| dev_tx_valid | output | 1 | Engine offers a word to the device |
| dev_tx_data | output | DW | Word toward the device |
| dev_tx_ready | input | 1 | Device takes the word |
| irq | output | 1 | Completion interrupt, level |

## Verification
The bench runs with a 64-byte page. This makes transfers that start just below a boundary, span three pages, or fill exactly one aligned page short enough to run one after another.

- A segment-length error would show up as a memory command in a foreign page within one tenure, or as the wrong tenure count.
- An engine that held the bus across segments would report one tenure where two or three were expected.
- A zero-length start that still requested the bus, or that never finished, would show up as a non-zero tenure count or a missing interrupt.
- A start accepted while busy would either corrupt the running transfer's word count or write a marker region the bench watches.
- A status read that failed to clear done would leave `irq` high.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_MOVE,
    ST_GAP,
    ST_FIN
  } mv_state_t;

  localparam logic [1:0] RIX_ADDR   = 2'd0;
  localparam logic [1:0] RIX_LEN    = 2'd1;
  localparam logic [1:0] RIX_CTRL   = 2'd2;
  localparam logic [1:0] RIX_STATUS = 2'd3;

  localparam logic DIR_TO_MEM = 1'b0;
  localparam logic DIR_TO_DEV = 1'b1;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             busy,
  input  logic             done_evt,
  output logic             go,
  output logic             go_dir,
  output logic [AW-1:0]    go_addr,
  output logic [LEN_W-1:0] go_len,
  output logic             irq
);

  logic [AW-1:0]    addr_q, addr_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             dir_q, dir_d;
  logic             done_q, done_d;
  logic             wr_addr, wr_len, wr_ctrl, rd_stat;

  assign wr_addr = reg_wr && (reg_addr == RIX_ADDR);
  assign wr_len  = reg_wr && (reg_addr == RIX_LEN);
  assign wr_ctrl = reg_wr && (reg_addr == RIX_CTRL);
  assign rd_stat = reg_rd && (reg_addr == RIX_STATUS);

  // start accepted only when the engine is idle
  assign go      = wr_ctrl && reg_wdata[1] && !busy;
  assign go_dir  = reg_wdata[0];
  assign go_addr = addr_q;
  assign go_len  = len_q;
  assign irq     = done_q;

  always_comb begin
    addr_d = addr_q;
    len_d  = len_q;
    dir_d  = dir_q;
    done_d = done_q;
    if (wr_addr) addr_d = reg_wdata[AW-1:0];
    if (wr_len)  len_d  = reg_wdata[LEN_W-1:0];
    if (wr_ctrl) dir_d  = reg_wdata[0];
    if (rd_stat) done_d = 1'b0;
    if (done_evt) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= addr_d;
      if (wr_len)  len_q  <= len_d;
      if (wr_ctrl) dir_q  <= dir_d;
      if (rd_stat || done_evt) done_q <= done_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RIX_ADDR:   reg_rdata[AW-1:0]    = addr_q;
      RIX_LEN:    reg_rdata[LEN_W-1:0] = len_q;
      RIX_CTRL:   reg_rdata[0]         = dir_q;
      default:    reg_rdata[1:0]       = {done_q, busy};
    endcase
  end

endmodule

// File: rtl/dma_seg_calc.sv
module dma_seg_calc #(
  parameter int LEN_W      = 24,
  parameter int PAGE_BYTES = 4096,
  parameter int WB_BITS    = 2,
  localparam int PG_BITS   = $clog2(PAGE_BYTES),
  localparam int CW        = (LEN_W > PG_BITS + 1) ? LEN_W : PG_BITS + 1
) (
  input  logic [PG_BITS-1:0] page_off,
  input  logic [LEN_W-1:0]   remain,
  output logic [CW-1:0]      seg_words
);

  logic [CW-1:0] to_bound;
  logic [CW-1:0] rem_ext;
  logic [CW-1:0] seg_bytes;

  always_comb begin
    to_bound  = CW'(PAGE_BYTES) - CW'(page_off);
    rem_ext   = CW'(remain);
    seg_bytes = (rem_ext < to_bound) ? rem_ext : to_bound;
    seg_words = seg_bytes >> WB_BITS;
  end

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LEN_W      = 24,
  parameter int PAGE_BYTES = 4096,
  localparam int WB        = DW / 8,
  localparam int WB_BITS   = $clog2(WB),
  localparam int PG_BITS   = $clog2(PAGE_BYTES),
  localparam int CW        = (LEN_W > PG_BITS + 1) ? LEN_W : PG_BITS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_dir,
  input  logic [AW-1:0]    go_addr,
  input  logic [LEN_W-1:0] go_len,
  output logic             busy,
  output logic             done_evt,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic             mem_cmd,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             dev_rx_valid,
  input  logic [DW-1:0]    dev_rx_data,
  output logic             dev_rx_ready,
  output logic             dev_tx_valid,
  output logic [DW-1:0]    dev_tx_data,
  input  logic             dev_tx_ready
);

  localparam logic [AW-1:0]    AMASK = ~AW'(WB - 1);
  localparam logic [LEN_W-1:0] LMASK = ~LEN_W'(WB - 1);

  mv_state_t        st_q, st_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [CW-1:0]    segw_q, segw_d;
  logic [DW-1:0]    buf_q, buf_d;
  logic             full_q, full_d;
  logic             dir_q, dir_d;
  logic [CW-1:0]    seg_words;
  logic             in_move, seg_left, pop, push, beat;

  dma_seg_calc #(
    .LEN_W     (LEN_W),
    .PAGE_BYTES(PAGE_BYTES),
    .WB_BITS   (WB_BITS)
  ) u_seg (
    .page_off (addr_q[PG_BITS-1:0]),
    .remain   (rem_q),
    .seg_words(seg_words)
  );

  assign in_move  = (st_q == ST_MOVE);
  assign seg_left = (segw_q != '0);

  assign dev_rx_ready = in_move && (dir_q == DIR_TO_MEM) && !full_q && seg_left;
  assign dev_tx_valid = in_move && (dir_q == DIR_TO_DEV) && full_q;
  assign dev_tx_data  = buf_q;
  assign pop          = dev_rx_ready && dev_rx_valid;
  assign push         = dev_tx_valid && dev_tx_ready;

  assign mem_req   = (st_q == ST_ARB) || in_move;
  assign mem_cmd   = in_move && seg_left && ((dir_q == DIR_TO_MEM) ? full_q : !full_q);
  assign mem_we    = (dir_q == DIR_TO_MEM);
  assign mem_addr  = addr_q;
  assign mem_wdata = buf_q;
  assign beat      = mem_cmd && mem_ack;

  assign busy     = (st_q != ST_IDLE);
  assign done_evt = (st_q == ST_FIN);

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    segw_d = segw_q;
    buf_d  = buf_q;
    full_d = full_q;
    dir_d  = dir_q;
    case (st_q)
      ST_IDLE: begin
        if (go) begin
          addr_d = go_addr & AMASK;
          rem_d  = go_len & LMASK;
          dir_d  = go_dir;
          full_d = 1'b0;
          st_d   = ((go_len & LMASK) == '0) ? ST_FIN : ST_ARB;
        end
      end
      ST_ARB: begin
        if (mem_gnt) begin
          segw_d = seg_words;
          st_d   = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (pop) begin
          buf_d  = dev_rx_data;
          full_d = 1'b1;
        end
        if (beat) begin
          addr_d = addr_q + AW'(WB);
          rem_d  = rem_q - LEN_W'(WB);
          segw_d = segw_q - 1'b1;
          if (dir_q == DIR_TO_DEV) begin
            buf_d  = mem_rdata;
            full_d = 1'b1;
          end else begin
            full_d = 1'b0;
          end
        end
        if (push) full_d = 1'b0;
        if (!seg_left && !full_q) st_d = (rem_q == '0) ? ST_FIN : ST_GAP;
      end
      ST_GAP:  st_d = ST_ARB;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      segw_q <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (go || beat) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
      end
      if (go) dir_q <= dir_d;
      if (beat || (st_q == ST_ARB)) segw_q <= segw_d;
      if (pop || (beat && dir_q == DIR_TO_DEV)) buf_q <= buf_d;
      full_q <= full_d;
    end
  end

endmodule

// File: rtl/dma_page_engine.sv
module dma_page_engine #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LEN_W      = 24,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_cmd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_rx_valid,
  input  logic [DW-1:0] dev_rx_data,
  output logic          dev_rx_ready,
  output logic          dev_tx_valid,
  output logic [DW-1:0] dev_tx_data,
  input  logic          dev_tx_ready,
  output logic          irq
);

  logic [1:0]       rs_q;
  logic             rst_n_i;
  logic             eng_busy, done_evt, go, go_dir;
  logic [AW-1:0]    go_addr;
  logic [LEN_W-1:0] go_len;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  dma_regs #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy     (eng_busy),
    .done_evt (done_evt),
    .go       (go),
    .go_dir   (go_dir),
    .go_addr  (go_addr),
    .go_len   (go_len),
    .irq      (irq)
  );

  dma_mover #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_mover (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .go          (go),
    .go_dir      (go_dir),
    .go_addr     (go_addr),
    .go_len      (go_len),
    .busy        (eng_busy),
    .done_evt    (done_evt),
    .mem_req     (mem_req),
    .mem_gnt     (mem_gnt),
    .mem_cmd     (mem_cmd),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .dev_rx_valid(dev_rx_valid),
    .dev_rx_data (dev_rx_data),
    .dev_rx_ready(dev_rx_ready),
    .dev_tx_valid(dev_tx_valid),
    .dev_tx_data (dev_tx_data),
    .dev_tx_ready(dev_tx_ready)
  );

endmodule

// File: rtl/dma_page_engine_chk.sv
module dma_page_engine_chk #(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 4096,
  localparam int PG_BITS   = $clog2(PAGE_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic [1:0]    reg_addr,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_cmd,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          dev_rx_ready,
  input logic          dev_tx_valid,
  input logic          busy,
  input logic          irq
);

  logic                  have_page;
  logic [AW-PG_BITS-1:0] tenure_page;
  logic                  stat_rd;

  assign stat_rd = reg_rd && (reg_addr == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_page   <= 1'b0;
      tenure_page <= '0;
    end else if (!mem_req) begin
      have_page <= 1'b0;
    end else if (mem_cmd && mem_ack && !have_page) begin
      have_page   <= 1'b1;
      tenure_page <= mem_addr[AW-1:PG_BITS];
    end
  end

  AST_CMD_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd |-> (mem_req && mem_gnt)); // R2

  AST_SEG_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd && have_page) |-> (mem_addr[AW-1:PG_BITS] == tenure_page)); // R5

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd && !mem_ack) |=> (mem_cmd && $stable(mem_addr))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !dev_rx_ready && !dev_tx_valid)); // R2

  AST_IRQ_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(busy)); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_rd) |=> irq); // R8

endmodule

bind dma_page_engine dma_page_engine_chk #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .mem_req     (mem_req),
  .mem_gnt     (mem_gnt),
  .mem_cmd     (mem_cmd),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .dev_rx_ready(dev_rx_ready),
  .dev_tx_valid(dev_tx_valid),
  .busy        (eng_busy),
  .irq         (irq)
);

// File: tb/tb_dma_page_engine.sv
module tb_dma_page_engine;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int PG = 64;

  logic          clk, rst_n;
  logic          reg_wr, reg_rd;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          mem_req, mem_gnt, mem_cmd, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          dev_rx_valid, dev_rx_ready, dev_tx_valid, dev_tx_ready;
  logic [DW-1:0] dev_rx_data, dev_tx_data;
  logic          irq;

  dma_page_engine #(.AW(AW), .DW(DW), .LEN_W(24), .PAGE_BYTES(PG)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_cmd(mem_cmd), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
    .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready),
    .irq(irq)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // memory / device model state
  logic [DW-1:0] mem [256];
  logic [DW-1:0] tx_log [64];
  int tenures, beats, page_err, rx_idx, tx_n, gnt_wait, ack_cnt, cyc;
  logic req_seen, have_pg, rx_pop_pending;
  logic [AW-1:0] cur_pg;
  logic [DW-1:0] rx_base;

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    summary_and_end();
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    tenures  = 0;
    beats    = 0;
    page_err = 0;
    rx_idx   = 0;
    tx_n     = 0;
  endtask

  // bus, memory and device responder, driven away from the active edge
  initial begin
    mem_gnt = 0; mem_ack = 0; mem_rdata = '0;
    dev_rx_valid = 0; dev_rx_data = '0; dev_tx_ready = 0;
    req_seen = 0; have_pg = 0; rx_pop_pending = 0; cur_pg = '0;
    gnt_wait = 0; ack_cnt = 0; cyc = 0; rx_base = 32'h1000_0000;
    clear_model();
    forever begin
      @(negedge clk);
      cyc++;
      if (mem_req && !req_seen) begin
        tenures++;
        have_pg = 0;
      end
      req_seen = mem_req;
      if (!mem_req) begin
        mem_gnt = 0;
        gnt_wait = 0;
      end else if (!mem_gnt) begin
        if (gnt_wait == 2) mem_gnt = 1;
        else gnt_wait++;
      end
      mem_ack = 0;
      if (mem_cmd && mem_gnt) begin
        ack_cnt++;
        if (ack_cnt % 3 != 0) begin
          mem_ack = 1;
          beats++;
          if (have_pg && (mem_addr / PG) != cur_pg) page_err++;
          cur_pg  = mem_addr / PG;
          have_pg = 1;
          if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[9:2]];
        end
      end
      if (rx_pop_pending) rx_idx++;
      dev_rx_data    = rx_base + DW'(rx_idx);
      dev_rx_valid   = (cyc % 4 != 0);
      rx_pop_pending = dev_rx_ready && dev_rx_valid;
      dev_tx_ready   = (cyc % 5 != 0);
      if (dev_tx_valid && dev_tx_ready && tx_n < 64) begin
        tx_log[tx_n] = dev_tx_data;
        tx_n++;
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin
        seen = 1;
        break;
      end
    end
  endtask

  task automatic launch(input logic [AW-1:0] a, input int len, input bit dir);
    reg_write(2'd0, a);
    reg_write(2'd1, DW'(len));
    reg_write(2'd2, {30'd0, 1'b1, dir});
  endtask

  task automatic finish_and_clear(input string tag);
    bit seen;
    logic [DW-1:0] st;
    wait_irq(seen);
    check(seen, {tag, " irq on completion"}, int'(seen), 1);
    reg_read(2'd3, st);
    check(st[1:0] == 2'b10, {tag, " status done, not busy"}, int'(st[1:0]), 2);
  endtask

  task automatic t_reset();
    logic [DW-1:0] st;
    check(irq == 0, "R11 irq after reset", int'(irq), 0);
    check(mem_req == 0, "R11 mem_req after reset", int'(mem_req), 0);
    reg_read(2'd3, st);
    check(st == 0, "R11 status after reset", int'(st), 0);
  endtask

  task automatic t_regs();
    logic [DW-1:0] v;
    reg_write(2'd0, 32'h0000_0123);
    reg_read(2'd0, v);
    check(v == 32'h123, "R1 address readback", int'(v), 32'h123);
    reg_write(2'd1, 32'h0000_0456);
    reg_read(2'd1, v);
    check(v == 32'h456, "R1 length readback", int'(v), 32'h456);
    reg_write(2'd2, 32'h0000_0001);
    reg_read(2'd2, v);
    check(v == 32'h1, "R1 control direction readback", int'(v), 1);
    reg_write(2'd2, 32'h0000_0000);
    check(mem_req == 0, "R1 control write without start stays idle", int'(mem_req), 0);
  endtask

  task automatic t_to_mem(input logic [AW-1:0] a, input int len, input int exp_ten, input string tag);
    int bad = 0;
    clear_model();
    rx_base = 32'h2000_0000 + a;
    launch(a, len, 1'b0);
    finish_and_clear(tag);
    for (int i = 0; i < len / 4; i++)
      if (mem[(a[9:2] + i) % 256] !== rx_base + DW'(i)) bad++;
    check(bad == 0, {tag, " R3 memory contents"}, bad, 0);
    check(beats == len / 4, {tag, " R3 beat count"}, beats, len / 4);
    check(tenures == exp_ten, {tag, " R6 tenure count"}, tenures, exp_ten);
    check(page_err == 0, {tag, " R5 one page per tenure"}, page_err, 0);
  endtask

  task automatic t_to_dev(input logic [AW-1:0] a, input int len, input int exp_ten, input string tag);
    int bad = 0;
    clear_model();
    for (int i = 0; i < len / 4; i++) mem[(a[9:2] + i) % 256] = 32'hA500_0000 + DW'(i);
    launch(a, len, 1'b1);
    finish_and_clear(tag);
    check(tx_n == len / 4, {tag, " R4 words delivered"}, tx_n, len / 4);
    for (int i = 0; i < len / 4 && i < tx_n; i++)
      if (tx_log[i] !== 32'hA500_0000 + DW'(i)) bad++;
    check(bad == 0, {tag, " R4 device data order"}, bad, 0);
    check(tenures == exp_ten, {tag, " R6 tenure count"}, tenures, exp_ten);
    check(page_err == 0, {tag, " R5 one page per tenure"}, page_err, 0);
  endtask

  task automatic t_zero_len();
    clear_model();
    launch(32'h40, 0, 1'b0);
    finish_and_clear("R9 zero length");
    check(tenures == 0, "R9 no bus request", tenures, 0);
    check(rx_idx == 0, "R9 no device transfer", rx_idx, 0);
  endtask

  task automatic t_busy_start();
    logic [DW-1:0] st;
    int bad = 0;
    for (int i = 0; i < 4; i++) mem[(32'h300 >> 2) + i] = 32'hDEAD_0000 + DW'(i);
    clear_model();
    rx_base = 32'h3000_0000;
    launch(32'h200, 128, 1'b0);
    reg_read(2'd3, st);
    check(st[0] == 1'b1, "R2 busy during transfer", int'(st[0]), 1);
    reg_write(2'd0, 32'h300);
    reg_write(2'd1, 32'd16);
    reg_write(2'd2, 32'h3);
    finish_and_clear("R10 first transfer");
    repeat (60) @(negedge clk);
    check(irq == 0, "R10 no second completion", int'(irq), 0);
    check(tenures == 2, "R10 tenure count unchanged", tenures, 2);
    check(beats == 32, "R10 beat count of first transfer", beats, 32);
    for (int i = 0; i < 4; i++) if (mem[(32'h300 >> 2) + i] !== 32'hDEAD_0000 + DW'(i)) bad++;
    check(bad == 0, "R10 ignored region untouched", bad, 0);
  endtask

  task automatic t_irq_clear();
    bit seen;
    logic [DW-1:0] st;
    clear_model();
    launch(32'h80, 8, 1'b0);
    wait_irq(seen);
    check(seen, "R7 irq rises", int'(seen), 1);
    repeat (5) @(negedge clk);
    check(irq == 1, "R8 irq held until status read", int'(irq), 1);
    reg_read(2'd3, st);
    check(st[1:0] == 2'b10, "R7 done set, busy clear", int'(st[1:0]), 2);
    check(irq == 0, "R8 irq cleared by status read", int'(irq), 0);
    reg_read(2'd3, st);
    check(st[1] == 1'b0, "R8 done cleared", int'(st[1]), 0);
  endtask

  initial begin
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_to_mem(32'h10, 16, 1, "R2 single page");
    t_to_mem(32'h38, 40, 2, "R5 boundary crossing");
    t_to_mem(32'h40, 64, 1, "R5 exact page");
    t_to_mem(32'h12B, 18, 1, "R1 low bits ignored");
    t_to_dev(32'h70, 96, 3, "R4 three pages");
    t_zero_len();
    t_busy_start();
    t_irq_clear();
    summary_and_end();
  end

endmodule